// File: doc/BRIEF.md
# Multi-Stage Watchdog Timer

This block is a watchdog that runs through four timeout stages in a fixed order. A 16-bit prescaler divides the input clock into a watchdog tick. Each stage counts its own number of ticks. When a stage expires, the block performs that stage's action and moves to the next stage. After the last stage the sequence starts again from stage 0. A stage action can be to do nothing, to raise an interrupt, to pulse the CPU reset, or to pulse the system reset. Each reset output has its own pulse width, chosen by a 3-bit selector from a fixed table that is not linear.

Software uses a simple write-only register port. It programs the stages and starts the block with the enable bit. To keep the block from acting, software writes the feed address, which restarts the sequence before a stage runs out. A write-protect word guards the configuration. While that word differs from the unlock key, writes to the control, prescale, timeout and feed addresses have no effect. The actual distribution of the reset pulses is left to the logic around the block.

Top module: `mswd_top`

## Requirements
- R1: After reset, `irq_level`, `irq_edge`, `cpu_rst` and `sys_rst` are all low. The watchdog is disabled and the protect word holds the unlock key 0x50D83AA1.
- R2: Let L be the prescale value, or 1 when the prescale value is 0. One watchdog tick occurs every L clocks. A stage with timeout T expires T*L clocks after the cycle in which it started (enable, feed or the previous expiry). A timeout of 0 behaves as 1.
- R3: Stages run in the order 0, 1, 2, 3, 0, and so on. A stage whose action code is 0 (off) expires without driving any output.
- R4: On the expiry of a stage with action code 1 (interrupt), while edge-enable (control bit 2) is set, `irq_edge` is high for exactly the one cycle after the expiry edge.
- R5: The expiry of an interrupt stage sets a sticky status bit. `irq_level` shows that status only while level-enable (control bit 1) is set. Any write to address 8 clears the status, and this clear is not write-protected.
- R6: On the expiry of a stage with action code 2, `cpu_rst` rises in the cycle after the expiry edge. It stays high for 8, 16, 24, 32, 40, 64, 128 or 256 clocks for selector values 0 to 7 (control bits 14:12).
- R7: On the expiry of a stage with action code 3, `sys_rst` gives a pulse with the same timing. The width comes from the same table, using the selector in control bits 18:16.
- R8: Any write to address 6 (feed) restarts the sequence at stage 0 with the tick count and the prescaler cleared. A feed that lands on the same edge as a stage expiry wins, and that expiry does not happen.
- R9: Clearing the enable bit (control bit 0) stops the sequence and returns it to stage 0 with all counts cleared. Enabling it again starts fresh.
- R10: Address 7 holds the protect word and accepts writes at any time. While that word is not 0x50D83AA1, writes to addresses 0 to 6 are ignored.
- R11: Register map: 0 is control. Its action codes sit at bits 5:4, 7:6, 9:8 and 11:10 for stages 0 to 3. Address 1 is prescale (16 bits) and addresses 2 to 5 are the 32-bit timeouts of stages 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one prescaler step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| irq_level | output | 1 | Sticky interrupt status gated by level-enable |
| irq_edge | output | 1 | One-cycle interrupt pulse per interrupt-stage expiry |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
A feed write and a stage expiry can fall on the same clock edge. The bench provokes this by timing a feed write to land exactly on the edge where stage 0 would expire. It then expects no interrupt on that edge and a single interrupt one full stage period after the feed. The second collision is a locked configuration write arriving while a running sequence moves forward. Here the bench expects the reset pulses at the times and widths the unchanged settings give. Every event is compared by start cycle and by width against a queue of predicted events, and any output event with no prediction is an error.

// File: rtl/mswd_pkg.sv
package mswd_pkg;

  localparam int NSTAGE = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 3;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h50D8_3AA1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
  localparam logic [ADDR_W-1:0] A_TMO0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_FEED  = 4'd6;
  localparam logic [ADDR_W-1:0] A_PROT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ICLR  = 4'd8;

  typedef enum logic [1:0] {
    ACT_OFF = 2'd0,
    ACT_IRQ = 2'd1,
    ACT_CPU = 2'd2,
    ACT_SYS = 2'd3
  } action_e;

  typedef struct packed {
    logic                   en;
    logic                   lvl_en;
    logic                   edge_en;
    action_e [NSTAGE-1:0]   act;
    logic [LEN_W-1:0]       cpu_len;
    logic [LEN_W-1:0]       sys_len;
  } ctrl_t;

endpackage

// File: rtl/mswd_regs.sv
module mswd_regs
  import mswd_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int TMO_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output ctrl_t                           cfg,
  output logic [PRE_W-1:0]                presc,
  output logic [NSTAGE-1:0][TMO_W-1:0]    tmo,
  output logic                            feed,
  output logic                            int_clr
);

  localparam int CTRL_ACT_LSB = 4;
  localparam int CTRL_CPU_LSB = 12;
  localparam int CTRL_SYS_LSB = 16;

  ctrl_t                        ctrl_q, ctrl_d;
  logic [PRE_W-1:0]             presc_q, presc_d;
  logic [NSTAGE-1:0][TMO_W-1:0] tmo_q, tmo_d;
  logic [DATA_W-1:0]            prot_q, prot_d;
  logic                         unlocked;
  logic                         wr_ok;

  assign unlocked = (prot_q == UNLOCK_KEY);
  assign wr_ok    = wr_en && unlocked;

  always_comb begin
    ctrl_d  = ctrl_q;
    presc_d = presc_q;
    tmo_d   = tmo_q;
    prot_d  = prot_q;
    if (wr_en && wr_addr == A_PROT) begin
      prot_d = wr_data;
    end
    if (wr_ok && wr_addr == A_CTRL) begin
      ctrl_d.en      = wr_data[0];
      ctrl_d.lvl_en  = wr_data[1];
      ctrl_d.edge_en = wr_data[2];
      for (int s = 0; s < NSTAGE; s++) begin
        ctrl_d.act[s] = action_e'(wr_data[CTRL_ACT_LSB + 2*s +: 2]);
      end
      ctrl_d.cpu_len = wr_data[CTRL_CPU_LSB +: LEN_W];
      ctrl_d.sys_len = wr_data[CTRL_SYS_LSB +: LEN_W];
    end
    if (wr_ok && wr_addr == A_PRESC) begin
      presc_d = wr_data[PRE_W-1:0];
    end
    for (int s = 0; s < NSTAGE; s++) begin
      if (wr_ok && wr_addr == A_TMO0 + ADDR_W'(s)) begin
        tmo_d[s] = wr_data[TMO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      tmo_q   <= '0;
      prot_q  <= UNLOCK_KEY;
    end else begin
      ctrl_q  <= ctrl_d;
      presc_q <= presc_d;
      tmo_q   <= tmo_d;
      prot_q  <= prot_d;
    end
  end

  assign cfg     = ctrl_q;
  assign presc   = presc_q;
  assign tmo     = tmo_q;
  assign feed    = wr_ok && (wr_addr == A_FEED);
  assign int_clr = wr_en && (wr_addr == A_ICLR);

  // R10: a control write while locked leaves the control word unchanged
  p_locked_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && prot_q != UNLOCK_KEY) |=> $stable(ctrl_q));

  // R10: a locked prescale write leaves the prescale value unchanged
  p_locked_presc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PRESC && prot_q != UNLOCK_KEY) |=> $stable(presc_q));

endmodule

// File: rtl/mswd_presc.sv
module mswd_presc #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] last;
  logic             wrap;

  assign last = (presc == '0) ? '0 : presc - PRE_W'(1);
  assign wrap = (pre_q >= last);
  assign tick = en && !clr && wrap;

  always_comb begin
    pre_d = pre_q;
    if (!en || clr) begin
      pre_d = '0;
    end else if (wrap) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  // R2: every tick starts a new prescale period from zero
  p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));

endmodule

// File: rtl/mswd_seq.sv
module mswd_seq
  import mswd_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          feed,
  input  logic                          tick,
  input  logic [NSTAGE-1:0][TMO_W-1:0]  tmo,
  input  action_e [NSTAGE-1:0]          act,
  output logic                          expire,
  output action_e                       exp_act
);

  localparam int SW = $clog2(NSTAGE);

  logic [SW-1:0]    stage_q, stage_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [TMO_W:0]   cnt_inc;
  logic             hit;
  logic [SW-1:0]    stage_nx;

  assign cnt_inc  = {1'b0, cnt_q} + (TMO_W+1)'(1);
  assign hit      = cnt_inc >= {1'b0, tmo[stage_q]};
  assign expire   = en && !feed && tick && hit;
  assign exp_act  = act[stage_q];
  assign stage_nx = (stage_q == SW'(NSTAGE-1)) ? '0 : stage_q + SW'(1);

  always_comb begin
    stage_d = stage_q;
    cnt_d   = cnt_q;
    if (!en || feed) begin
      stage_d = '0;
      cnt_d   = '0;
    end else if (expire) begin
      stage_d = stage_nx;
      cnt_d   = '0;
    end else if (tick) begin
      cnt_d   = cnt_q + TMO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_d;
      cnt_q   <= cnt_d;
    end
  end

  // R9: a disabled watchdog sits at stage 0 with a zero count
  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (stage_q == '0 && cnt_q == '0));

  // R8: a feed restarts the sequence
  p_feed_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (stage_q == '0 && cnt_q == '0));

  // R3: an expiry moves to the following stage, wrapping after the last one
  p_stage_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (stage_q == (($past(stage_q) == SW'(NSTAGE-1)) ? '0
                                                              : $past(stage_q) + SW'(1))));

endmodule

// File: rtl/mswd_pulse.sv
module mswd_pulse
  import mswd_pkg::*;
#(
  parameter int UNIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [LEN_W-1:0] sel,
  output logic             pulse
);

  localparam int CW = $clog2(UNIT * 32 + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len;

  // widths grow linearly for the short settings, then double
  always_comb begin
    if (sel < LEN_W'(5)) begin
      len = CW'((int'(sel) + 1) * UNIT);
    end else begin
      len = CW'(UNIT << (int'(sel) - 2));
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (trig) begin
      cnt_d = len;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse = (cnt_q != '0);

  // R6 and R7: a running pulse counts down one per clock
  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R6 and R7: a trigger always opens a pulse on the next cycle
  p_trig_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);

endmodule

// File: rtl/mswd_top.sv
module mswd_top
  import mswd_pkg::*;
#(
  parameter int PRE_W    = 16,
  parameter int TMO_W    = 32,
  parameter int LEN_UNIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic              irq_level,
  output logic              irq_edge,
  output logic              cpu_rst,
  output logic              sys_rst
);

  localparam int NRST = 2;

  logic [1:0]                   rs_q;
  logic                         rst_int_n;
  ctrl_t                        cfg;
  logic [PRE_W-1:0]             presc;
  logic [NSTAGE-1:0][TMO_W-1:0] tmo;
  logic                         feed;
  logic                         int_clr;
  logic                         tick;
  logic                         expire;
  action_e                      exp_act;
  logic                         set_irq;
  logic                         raw_q, raw_d;
  logic                         edge_q, edge_d;
  logic [NRST-1:0]              rst_trig;
  logic [NRST-1:0][LEN_W-1:0]   rst_sel;
  logic [NRST-1:0]              rst_out;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  mswd_regs #(.PRE_W(PRE_W), .TMO_W(TMO_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg),
    .presc   (presc),
    .tmo     (tmo),
    .feed    (feed),
    .int_clr (int_clr)
  );

  mswd_presc #(.PRE_W(PRE_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (cfg.en),
    .clr   (feed),
    .presc (presc),
    .tick  (tick)
  );

  mswd_seq #(.TMO_W(TMO_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (cfg.en),
    .feed    (feed),
    .tick    (tick),
    .tmo     (tmo),
    .act     (cfg.act),
    .expire  (expire),
    .exp_act (exp_act)
  );

  assign set_irq = expire && (exp_act == ACT_IRQ);

  // a new event outranks a clear in the same cycle
  always_comb begin
    raw_d  = (raw_q && !int_clr) || set_irq;
    edge_d = set_irq && cfg.edge_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      raw_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      edge_q <= edge_d;
    end
  end

  assign irq_level = raw_q && cfg.lvl_en;
  assign irq_edge  = edge_q;

  assign rst_trig[0] = expire && (exp_act == ACT_CPU);
  assign rst_trig[1] = expire && (exp_act == ACT_SYS);
  assign rst_sel[0]  = cfg.cpu_len;
  assign rst_sel[1]  = cfg.sys_len;

  for (genvar g = 0; g < NRST; g++) begin : g_rst
    mswd_pulse #(.UNIT(LEN_UNIT)) u_pulse (
      .clk   (clk),
      .rst_n (rst_int_n),
      .trig  (rst_trig[g]),
      .sel   (rst_sel[g]),
      .pulse (rst_out[g])
    );
  end

  assign cpu_rst = rst_out[0];
  assign sys_rst = rst_out[1];

  // R5: an interrupt-stage expiry always leaves the status set
  p_status_set_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    set_irq |=> raw_q);

  // R4: the edge output follows only an interrupt-stage expiry
  p_edge_cause_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_edge |-> $past(set_irq));

  // R3: at most one reset action per expiry
  p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(rst_trig));

endmodule

// File: tb/test_mswd_top.sv
module test_mswd_top;
  import mswd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        irq_level, irq_edge, cpu_rst, sys_rst;

  always #2.5 clk = ~clk;

  mswd_top i_mswd_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq_level (irq_level),
    .irq_edge  (irq_edge),
    .cpu_rst   (cpu_rst),
    .sys_rst   (sys_rst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  int last_t = 0;
  bit finished = 0;

  typedef struct {
    int start;
    int width;
    int req;
  } ev_t;

  ev_t q_irq[$];
  ev_t q_cpu[$];
  ev_t q_sys[$];
  logic prev_v[3] = '{1'b0, 1'b0, 1'b0};
  int   st_c[3]   = '{0, 0, 0};

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int qsize(int k);
    case (k)
      0:       return q_irq.size();
      1:       return q_cpu.size();
      default: return q_sys.size();
    endcase
  endfunction

  function automatic ev_t qpop(int k);
    case (k)
      0:       return q_irq.pop_front();
      1:       return q_cpu.pop_front();
      default: return q_sys.pop_front();
    endcase
  endfunction

  // monitor: compares each observed pulse with the front of its queue
  task automatic observe(int k, logic v);
    ev_t e;
    if (v && !prev_v[k]) begin
      st_c[k] = cyc;
      if (qsize(k) == 0) begin
        // R3: off stages and stopped sequences must not produce events
        n_chk++;
        n_err++;
        $display("FAIL R3 unexpected event on output %0d actual start %0d expected none", k, cyc);
      end
    end
    if (!v && prev_v[k] && qsize(k) != 0) begin
      e = qpop(k);
      check(e.start == st_c[k], $sformatf("R%0d start of output %0d", e.req, k), st_c[k], e.start);
      check(e.width == cyc - st_c[k], $sformatf("R%0d width of output %0d", e.req, k),
            cyc - st_c[k], e.width);
    end
    prev_v[k] = v;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      observe(0, irq_edge);
      observe(1, cpu_rst);
      observe(2, sys_rst);
    end
  end

  task automatic push(int k, int start, int width, int req);
    ev_t e;
    e.start = start;
    e.width = width;
    e.req   = req;
    case (k)
      0:       q_irq.push_back(e);
      1:       q_cpu.push_back(e);
      default: q_sys.push_back(e);
    endcase
  endtask

  // driver: called at a falling edge, the write lands on the next rising edge
  task automatic wr_now(logic [3:0] a, logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    #1 last_t = cyc;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // R11: control word layout
  function automatic logic [31:0] mk_ctrl(bit en, bit lvl, bit edg, action_e a0, action_e a1,
                                          action_e a2, action_e a3, int cl, int sl);
    logic [31:0] w;
    w        = '0;
    w[0]     = en;
    w[1]     = lvl;
    w[2]     = edg;
    w[5:4]   = a0;
    w[7:6]   = a1;
    w[9:8]   = a2;
    w[11:10] = a3;
    w[14:12] = 3'(cl);
    w[18:16] = 3'(sl);
    return w;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual %0d expected below 200000", cyc);
    summary();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(irq_level == 1'b0, "R1 irq_level after reset", int'(irq_level), 0);
    check(irq_edge  == 1'b0, "R1 irq_edge after reset", int'(irq_edge), 0);
    check(cpu_rst   == 1'b0, "R1 cpu_rst after reset", int'(cpu_rst), 0);
    check(sys_rst   == 1'b0, "R1 sys_rst after reset", int'(sys_rst), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Scenario A, R2 R3 R4 R6 R7: all four actions, prescale 4
    wr(A_PRESC, 32'd4);
    wr(4'd2, 32'd3);
    wr(4'd3, 32'd2);
    wr(4'd4, 32'd5);
    wr(4'd5, 32'd2);
    wr(A_CTRL, mk_ctrl(1, 1, 1, ACT_IRQ, ACT_CPU, ACT_OFF, ACT_SYS, 5, 0));
    t0 = last_t;
    push(0, t0 + 12, 1, 4);
    push(1, t0 + 20, 64, 6);
    push(2, t0 + 48, 8, 7);
    push(0, t0 + 60, 1, 3);
    wait_until(t0 + 14);
    check(irq_level == 1'b1, "R5 level status after interrupt stage", int'(irq_level), 1);
    wr(A_ICLR, 32'd0);
    check(irq_level == 1'b0, "R5 level status after clear", int'(irq_level), 0);
    wait_until(t0 + 61);
    wr_now(A_CTRL, mk_ctrl(0, 0, 0, ACT_IRQ, ACT_CPU, ACT_OFF, ACT_SYS, 5, 0));
    repeat (300) @(negedge clk);
    check(q_irq.size() + q_cpu.size() + q_sys.size() == 0, "R9 all events of scenario A seen",
          q_irq.size() + q_cpu.size() + q_sys.size(), 0);
    wr(A_ICLR, 32'd0);

    // Scenario B, R8: feed lands on the expiry edge, level disabled
    wr(A_PRESC, 32'd2);
    wr(4'd2, 32'd4);
    wr(4'd3, 32'd1000);
    wr(4'd4, 32'd1000);
    wr(4'd5, 32'd1000);
    wr(A_CTRL, mk_ctrl(1, 0, 1, ACT_IRQ, ACT_OFF, ACT_OFF, ACT_OFF, 0, 0));
    t0 = last_t;
    push(0, t0 + 16, 1, 8);
    wait_until(t0 + 7);
    wr_now(A_FEED, 32'h1234);
    wait_until(t0 + 18);
    check(irq_level == 1'b0, "R5 level output masked", int'(irq_level), 0);
    wait_until(t0 + 20);
    wr_now(A_CTRL, 32'd0);
    repeat (50) @(negedge clk);
    check(q_irq.size() == 0, "R8 delayed interrupt seen", q_irq.size(), 0);
    wr(A_ICLR, 32'd0);

    // Scenario C, R10: locked writes ignored while running
    wr(A_PRESC, 32'd1);
    wr(4'd2, 32'd10);
    wr(4'd3, 32'd30);
    wr(A_CTRL, mk_ctrl(1, 0, 0, ACT_CPU, ACT_SYS, ACT_OFF, ACT_OFF, 1, 7));
    t0 = last_t;
    push(1, t0 + 10, 16, 10);
    push(2, t0 + 40, 256, 7);
    wr_now(A_PROT, 32'd0);
    wr_now(A_CTRL, 32'd0);
    wr_now(A_FEED, 32'd0);
    wr_now(A_PRESC, 32'd50);
    wait_until(t0 + 45);
    wr_now(A_PROT, UNLOCK_KEY);
    wr_now(A_CTRL, 32'd0);
    repeat (300) @(negedge clk);
    check(q_cpu.size() == 0, "R10 cpu event despite locked writes", q_cpu.size(), 0);
    check(q_sys.size() == 0, "R7 long system pulse seen", q_sys.size(), 0);
    check(cpu_rst == 1'b0 && sys_rst == 1'b0, "R9 outputs quiet when stopped",
          int'(cpu_rst) + int'(sys_rst), 0);
    summary();
  end

endmodule